// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits in front of a sector write buffer and watches every byte-load event, each carrying a 15-bit address and an 8-bit data value. It looks for fixed multi-cycle command codes. Each code begins with a two-cycle key (0xAA written to 0x5555, then 0x55 written to 0x2AAA), and the third cycle selects the command. The commands switch software write protection on or off and move the read path into or out of an identification mode. Command cycles are consumed. Any other load either reaches the buffer or is discarded, depending on the protection state.

A run of loads opens a load window. When no load arrives for a set number of cycles, the window closes and the block pulses a start request to the external program timer. The request carries a flag that tells the program path to leave the array untouched when the window was not authorised. The protection flag changes only when the timer reports that the program period has ended. This flag is cleared by the power-up reset alone. A warm reset clears only the sequence and window state.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After power-up reset (`por_n` low), `prot_on`, `id_mode`, `buf_wr` and `prog_start` are 0, and `rd_data` equals `arr_rdata`.
- R2: While protection is off, a load that is not a command cycle gives `buf_wr`=1 on the next cycle, with `buf_addr`/`buf_data` equal to the load, and it opens a load window.
- R3: When `LOAD_WINDOW` cycles pass after the last accepted load with a window open, `prog_start` is high for exactly one cycle. `prog_blank` is high when the window was not authorised. A partial command sequence left idle for that long is dropped with no `prog_start`.
- R4: The cycles AA@5555, 55@2AAA, A0@5555 are consumed (`buf_wr`=0) and authorise the loads that follow. `prot_on` becomes 1 on the cycle after the `prog_done` that ends that program period, and not earlier.
- R5: While protection is on, a load not preceded by the A0 code is not forwarded. Its window still ends with `prog_start`=1 and `prog_blank`=1.
- R6: The six cycles AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 are consumed and authorise the loads that follow. `prot_on` becomes 0 after the `prog_done` that ends that program period.
- R7: The cycles AA@5555, 55@2AAA, 90@5555 set `id_mode` exactly `ID_PAUSE` cycles after the last of them. While `id_mode` is 1, `rd_data` is 0x1F when `rd_lsb`=0 and 0x5D when `rd_lsb`=1. The same key followed by F0@5555 clears `id_mode` after the same pause, and `rd_data` then returns `arr_rdata`.
- R8: A load that breaks a sequence after the key has started returns the decoder to idle. That load is then handled as an ordinary load: it is forwarded when protection is off and discarded when protection is on.
- R9: Loads are ignored (no `buf_wr`, no window) from `prog_start` until `prog_done`, and during the identification pause.
- R10: A warm reset (`rst_n` low) leaves `prot_on` and `id_mode` unchanged and clears any partial sequence.
- R11: Inside an open load window, every load is data, even one that matches a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, clears everything including protection |
| rst_n | input | 1 | Warm reset, active low, clears sequence and window state only |
| ld_valid | input | 1 | Byte-load event strobe |
| ld_addr | input | 15 | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| prog_done | input | 1 | Program timer reports end of program period |
| rd_lsb | input | 1 | Lowest read address bit, selects identifier byte |
| arr_rdata | input | 8 | Read data from the array |
| buf_wr | output | 1 | Forward a load to the sector buffer |
| buf_addr | output | 15 | Forwarded address |
| buf_data | output | 8 | Forwarded data |
| prog_start | output | 1 | One-cycle start request to the program timer |
| prog_blank | output | 1 | With `prog_start`: leave the array unchanged |
| prot_on | output | 1 | Persistent software protection flag |
| id_mode | output | 1 | Identification mode active |
| rd_data | output | 8 | Read data returned to the host |

## Verification
The bench builds the block with `LOAD_WINDOW`=8 and `ID_PAUSE`=5. With these values the inter-load timeout and the identification pause expire within a few cycles, so the bench can check the exact cycle of each `prog_start` pulse and each `id_mode` change. The short window also lets one run go through enable, protected, disable and mismatch sequences back to back, as well as warm and power-up resets taken mid-sequence.

// File: rtl/uscd_pkg.sv
package uscd_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DATA_B = 8'h55;
    localparam logic [DATA_W-1:0] OP_PROT_SET = 8'hA0;
    localparam logic [DATA_W-1:0] OP_EXTEND   = 8'h80;
    localparam logic [DATA_W-1:0] OP_PROT_CLR = 8'h20;
    localparam logic [DATA_W-1:0] OP_ID_ON    = 8'h90;
    localparam logic [DATA_W-1:0] OP_ID_OFF   = 8'hF0;

    typedef enum logic [2:0] {
        CM_NONE,
        CM_KEY1,
        CM_KEY2,
        CM_SET,
        CM_EXT,
        CM_CLR,
        CM_IDON,
        CM_IDOFF
    } cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_X3,
        SQ_X4,
        SQ_X5
    } seq_e;

    typedef enum logic [1:0] {
        PA_NONE,
        PA_SET,
        PA_CLR
    } pend_e;

    typedef struct packed {
        seq_e              seq;
        logic              loading;
        logic              auth;
        logic              busy;
        pend_e             pend;
        logic              id_wait;
        logic              id_tgt;
        logic              buf_wr;
        logic [ADDR_W-1:0] buf_addr;
        logic [DATA_W-1:0] buf_data;
        logic              prog_start;
        logic              prog_blank;
    } core_t;

    typedef struct packed {
        logic prot;
        logic id_mode;
    } keep_t;

endpackage

// File: rtl/uscd_match.sv
module uscd_match
    import uscd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_e              code
);

    always_comb begin
        code = CM_NONE;
        if (addr == KEY_ADDR_A && data == KEY_DATA_A) begin
            code = CM_KEY1;
        end else if (addr == KEY_ADDR_B && data == KEY_DATA_B) begin
            code = CM_KEY2;
        end else if (addr == KEY_ADDR_A) begin
            case (data)
                OP_PROT_SET: code = CM_SET;
                OP_EXTEND:   code = CM_EXT;
                OP_PROT_CLR: code = CM_CLR;
                OP_ID_ON:    code = CM_IDON;
                OP_ID_OFF:   code = CM_IDOFF;
                default:     code = CM_NONE;
            endcase
        end
    end

endmodule

// File: rtl/uscd_timer.sv
module uscd_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LIMIT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == CW'(1));

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import uscd_pkg::*;
#(
    parameter int          LOAD_WINDOW = 7500,
    parameter int          ID_PAUSE    = 500000,
    parameter logic [7:0]  MFR_CODE    = 8'h1F,
    parameter logic [7:0]  DEV_CODE    = 8'h5D
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        ld_valid,
    input  logic [14:0] ld_addr,
    input  logic [7:0]  ld_data,
    input  logic        prog_done,
    input  logic        rd_lsb,
    input  logic [7:0]  arr_rdata,
    output logic        buf_wr,
    output logic [14:0] buf_addr,
    output logic [7:0]  buf_data,
    output logic        prog_start,
    output logic        prog_blank,
    output logic        prot_on,
    output logic        id_mode,
    output logic [7:0]  rd_data
);

    core_t core_d, core_q;
    keep_t keep_d, keep_q;
    cmd_e  code;
    logic  srst_n;
    logic  ld_acc;
    logic  to_exp;
    logic  id_exp;
    logic  id_start;

    assign srst_n = por_n & rst_n;
    assign ld_acc = ld_valid & ~core_q.busy & ~core_q.id_wait;
    assign id_start = ld_acc & ~core_q.loading & (core_q.seq == SQ_K2) &
                      ((code == CM_IDON) | (code == CM_IDOFF));

    uscd_match u_match (
        .addr (ld_addr),
        .data (ld_data),
        .code (code)
    );

    uscd_timer #(.LIMIT(LOAD_WINDOW)) u_load_tmr (
        .clk     (clk),
        .rst_n   (srst_n),
        .start   (ld_acc),
        .expired (to_exp)
    );

    uscd_timer #(.LIMIT(ID_PAUSE)) u_id_tmr (
        .clk     (clk),
        .rst_n   (srst_n),
        .start   (id_start),
        .expired (id_exp)
    );

    always_comb begin
        logic plain;
        plain          = 1'b0;
        core_d         = core_q;
        keep_d         = keep_q;
        core_d.buf_wr     = 1'b0;
        core_d.prog_start = 1'b0;
        core_d.prog_blank = 1'b0;

        if (ld_acc) begin
            if (core_q.loading) begin
                plain = 1'b1;
            end else begin
                case (core_q.seq)
                    SQ_IDLE: begin
                        if (code == CM_KEY1) core_d.seq = SQ_K1;
                        else                 plain = 1'b1;
                    end
                    SQ_K1: begin
                        if (code == CM_KEY2) core_d.seq = SQ_K2;
                        else                 plain = 1'b1;
                    end
                    SQ_K2: begin
                        core_d.seq = SQ_IDLE;
                        case (code)
                            CM_SET: begin
                                core_d.loading = 1'b1;
                                core_d.auth    = 1'b1;
                                core_d.pend    = PA_SET;
                            end
                            CM_EXT:   core_d.seq = SQ_X3;
                            CM_IDON: begin
                                core_d.id_wait = 1'b1;
                                core_d.id_tgt  = 1'b1;
                            end
                            CM_IDOFF: begin
                                core_d.id_wait = 1'b1;
                                core_d.id_tgt  = 1'b0;
                            end
                            default:  plain = 1'b1;
                        endcase
                    end
                    SQ_X3: begin
                        if (code == CM_KEY1) core_d.seq = SQ_X4;
                        else                 plain = 1'b1;
                    end
                    SQ_X4: begin
                        if (code == CM_KEY2) core_d.seq = SQ_X5;
                        else                 plain = 1'b1;
                    end
                    SQ_X5: begin
                        if (code == CM_CLR) begin
                            core_d.seq     = SQ_IDLE;
                            core_d.loading = 1'b1;
                            core_d.auth    = 1'b1;
                            core_d.pend    = PA_CLR;
                        end else begin
                            plain = 1'b1;
                        end
                    end
                    default: plain = 1'b1;
                endcase
            end

            if (plain) begin
                core_d.seq      = SQ_IDLE;
                core_d.buf_addr = ld_addr;
                core_d.buf_data = ld_data;
                if (core_q.loading) begin
                    core_d.buf_wr = core_q.auth;
                end else begin
                    core_d.loading = 1'b1;
                    core_d.auth    = ~keep_q.prot;
                    core_d.buf_wr  = ~keep_q.prot;
                end
            end
        end else if (to_exp) begin
            core_d.seq = SQ_IDLE;
            if (core_q.loading) begin
                core_d.loading    = 1'b0;
                core_d.auth       = 1'b0;
                core_d.busy       = 1'b1;
                core_d.prog_start = 1'b1;
                core_d.prog_blank = ~core_q.auth;
            end
        end

        if (id_exp && core_q.id_wait) begin
            core_d.id_wait = 1'b0;
            keep_d.id_mode = core_q.id_tgt;
        end

        if (prog_done && core_q.busy) begin
            core_d.busy = 1'b0;
            case (core_q.pend)
                PA_SET:  keep_d.prot = 1'b1;
                PA_CLR:  keep_d.prot = 1'b0;
                default: keep_d.prot = keep_q.prot;
            endcase
            core_d.pend = PA_NONE;
        end
    end

    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            core_q <= '{seq: SQ_IDLE, pend: PA_NONE, default: '0};
        end else begin
            core_q <= core_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            keep_q <= '0;
        end else begin
            keep_q <= keep_d;
        end
    end

    assign buf_wr     = core_q.buf_wr;
    assign buf_addr   = core_q.buf_addr;
    assign buf_data   = core_q.buf_data;
    assign prog_start = core_q.prog_start;
    assign prog_blank = core_q.prog_blank;
    assign prot_on    = keep_q.prot;
    assign id_mode    = keep_q.id_mode;
    assign rd_data    = keep_q.id_mode ? (rd_lsb ? DEV_CODE : MFR_CODE) : arr_rdata;

endmodule

// File: rtl/uscd_checker.sv
module uscd_checker (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        ld_valid,
    input logic [14:0] ld_addr,
    input logic [7:0]  ld_data,
    input logic        prog_done,
    input logic        buf_wr,
    input logic [14:0] buf_addr,
    input logic [7:0]  buf_data,
    input logic        prog_start,
    input logic        prog_blank,
    input logic        prot_on
);

    AST_BUF_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        buf_wr |-> ($past(ld_valid) && buf_addr == $past(ld_addr) && buf_data == $past(ld_data))); // R2

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        prog_start |=> !prog_start); // R3

    AST_BLANK_ONLY_PROTECTED: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        (prog_start && prog_blank) |-> prot_on); // R5

    AST_PROT_MOVES_AT_DONE: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        !$stable(prot_on) |-> $past(prog_done)); // R4 R6

    AST_NO_WRITE_AT_START: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        prog_start |-> !buf_wr); // R9

endmodule

bind unlock_seq_decoder uscd_checker u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .prog_done  (prog_done),
    .buf_wr     (buf_wr),
    .buf_addr   (buf_addr),
    .buf_data   (buf_data),
    .prog_start (prog_start),
    .prog_blank (prog_blank),
    .prot_on    (prot_on)
);

// File: tb/sim_unlock_seq_decoder.sv
module sim_unlock_seq_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 8;
    localparam int PAUSE      = 5;
    localparam logic [7:0] ARR = 8'hC3;

    logic        clk = 1'b0;
    logic        por_n, rst_n, ld_valid, prog_done, rd_lsb;
    logic [14:0] ld_addr;
    logic [7:0]  ld_data, arr_rdata;
    logic        buf_wr, prog_start, prog_blank, prot_on, id_mode;
    logic [14:0] buf_addr;
    logic [7:0]  buf_data, rd_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unlock_seq_decoder #(.LOAD_WINDOW(WIN), .ID_PAUSE(PAUSE)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_data(ld_data), .prog_done(prog_done),
        .rd_lsb(rd_lsb), .arr_rdata(arr_rdata), .buf_wr(buf_wr),
        .buf_addr(buf_addr), .buf_data(buf_data), .prog_start(prog_start),
        .prog_blank(prog_blank), .prot_on(prot_on), .id_mode(id_mode),
        .rd_data(rd_data)
    );

    // op 0: load (e = expected buf_wr); op 1: wait window end (e = expected prog_blank);
    // op 2: prog_done pulse (e = expected prot_on afterwards)
    typedef struct packed {
        logic [1:0]  op;
        logic [14:0] a;
        logic [7:0]  d;
        logic        e;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 15'h0100, 8'h11, 1'b1},  // R2 plain load forwarded
        '{2'd0, 15'h0101, 8'h22, 1'b1},  // R2
        '{2'd1, 15'h0000, 8'h00, 1'b0},  // R3 window ends, authorised
        '{2'd2, 15'h0000, 8'h00, 1'b0},  // R3
        '{2'd0, 15'h5555, 8'hAA, 1'b0},  // R4 key 1 consumed
        '{2'd0, 15'h2AAA, 8'h55, 1'b0},  // R4 key 2 consumed
        '{2'd0, 15'h5555, 8'hA0, 1'b0},  // R4 enable code consumed
        '{2'd0, 15'h0200, 8'h33, 1'b1},  // R4 authorised load
        '{2'd1, 15'h0000, 8'h00, 1'b0},  // R4
        '{2'd2, 15'h0000, 8'h00, 1'b1},  // R4 protection set at done
        '{2'd0, 15'h0300, 8'h44, 1'b0},  // R5 unlocked load dropped
        '{2'd1, 15'h0000, 8'h00, 1'b1},  // R5 blank program period
        '{2'd2, 15'h0000, 8'h00, 1'b1},  // R5
        '{2'd0, 15'h5555, 8'hAA, 1'b0},  // R5 protected write with code
        '{2'd0, 15'h2AAA, 8'h55, 1'b0},  // R5
        '{2'd0, 15'h5555, 8'hA0, 1'b0},  // R5
        '{2'd0, 15'h0301, 8'h55, 1'b1},  // R5
        '{2'd1, 15'h0000, 8'h00, 1'b0},  // R5
        '{2'd2, 15'h0000, 8'h00, 1'b1},  // R5
        '{2'd0, 15'h5555, 8'hAA, 1'b0},  // R8 key then mismatch
        '{2'd0, 15'h2AAA, 8'h12, 1'b0},  // R8 discarded when protected
        '{2'd1, 15'h0000, 8'h00, 1'b1},  // R8
        '{2'd2, 15'h0000, 8'h00, 1'b1},  // R8
        '{2'd0, 15'h5555, 8'hAA, 1'b0},  // R6 six-cycle disable
        '{2'd0, 15'h2AAA, 8'h55, 1'b0},  // R6
        '{2'd0, 15'h5555, 8'h80, 1'b0},  // R6
        '{2'd0, 15'h5555, 8'hAA, 1'b0},  // R6
        '{2'd0, 15'h2AAA, 8'h55, 1'b0},  // R6
        '{2'd0, 15'h5555, 8'h20, 1'b0},  // R6
        '{2'd0, 15'h0400, 8'h66, 1'b1},  // R6 authorised load
        '{2'd1, 15'h0000, 8'h00, 1'b0},  // R6
        '{2'd2, 15'h0000, 8'h00, 1'b0},  // R6 protection cleared
        '{2'd0, 15'h5555, 8'hAA, 1'b0},  // R8 mismatch unprotected
        '{2'd0, 15'h0010, 8'h77, 1'b1},  // R8 forwarded as ordinary load
        '{2'd1, 15'h0000, 8'h00, 1'b0},  // R8
        '{2'd2, 15'h0000, 8'h00, 1'b0},  // R8
        '{2'd0, 15'h0500, 8'h01, 1'b1},  // R11 window open
        '{2'd0, 15'h5555, 8'hAA, 1'b1},  // R11 command bytes as data
        '{2'd0, 15'h2AAA, 8'h55, 1'b1},  // R11
        '{2'd0, 15'h5555, 8'hA0, 1'b1},  // R11
        '{2'd1, 15'h0000, 8'h00, 1'b0},  // R11
        '{2'd2, 15'h0000, 8'h00, 1'b0},  // R11 protection still off
        '{2'd0, 15'h0600, 8'h99, 1'b1},  // R9 start of a window
        '{2'd1, 15'h0000, 8'h00, 1'b0},  // R9
        '{2'd0, 15'h0601, 8'h98, 1'b0}   // R9 ignored while busy
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [14:0] a, input logic [7:0] d, input logic e, input string req);
        ld_valid = 1'b1;
        ld_addr  = a;
        ld_data  = d;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        chk(buf_wr == e, req, buf_wr, e);
        if (e) chk(buf_addr == a && buf_data == d, req, {buf_addr, buf_data}, {a, d});
    endtask

    task automatic do_wait(input logic blank, input string req);
        logic early;
        early = 1'b0;
        for (int k = 0; k < WIN - 1; k++) begin
            @(negedge clk);
            if (prog_start) early = 1'b1;
        end
        chk(!early, req, early, 0);
        @(negedge clk);
        chk(prog_start && prog_blank == blank, req, {prog_start, prog_blank}, {1'b1, blank});
    endtask

    task automatic do_done(input logic ep, input string req);
        prog_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        prog_done = 1'b0;
        chk(prot_on == ep, req, prot_on, ep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; ld_valid = 1'b0; prog_done = 1'b0;
        rd_lsb = 1'b0; ld_addr = '0; ld_data = '0; arr_rdata = ARR;
        repeat (2) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!prot_on && !id_mode && !buf_wr && !prog_start, "R1",
            {prot_on, id_mode, buf_wr, prog_start}, 0);
        chk(rd_data == ARR, "R1", rd_data, ARR);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: do_load(VEC[i].a, VEC[i].d, VEC[i].e, $sformatf("vec%0d", i));
                2'd1: do_wait(VEC[i].e, $sformatf("vec%0d", i));
                default: do_done(VEC[i].e, $sformatf("vec%0d", i));
            endcase
        end
        do_done(1'b0, "R9");

        // R7 identification entry, with a load ignored during the pause (R9)
        do_load(15'h5555, 8'hAA, 1'b0, "R7");
        do_load(15'h2AAA, 8'h55, 1'b0, "R7");
        do_load(15'h5555, 8'h90, 1'b0, "R7");
        do_load(15'h0700, 8'h12, 1'b0, "R9");
        begin
            logic early;
            early = 1'b0;
            for (int k = 0; k < PAUSE - 2; k++) begin
                @(negedge clk);
                if (id_mode || rd_data != ARR) early = 1'b1;
            end
            chk(!early, "R7", early, 0);
        end
        @(negedge clk);
        chk(id_mode, "R7", id_mode, 1);
        rd_lsb = 1'b0; #1;
        chk(rd_data == 8'h1F, "R7", rd_data, 8'h1F);
        rd_lsb = 1'b1; #1;
        chk(rd_data == 8'h5D, "R7", rd_data, 8'h5D);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(id_mode, "R10", id_mode, 1);
        do_load(15'h5555, 8'hAA, 1'b0, "R7");
        do_load(15'h2AAA, 8'h55, 1'b0, "R7");
        do_load(15'h5555, 8'hF0, 1'b0, "R7");
        repeat (PAUSE) @(negedge clk);
        #1;
        chk(!id_mode && rd_data == ARR, "R7", {id_mode, rd_data}, {1'b0, ARR});

        // R10 warm reset mid-sequence keeps protection
        do_load(15'h5555, 8'hAA, 1'b0, "R4");
        do_load(15'h2AAA, 8'h55, 1'b0, "R4");
        do_load(15'h5555, 8'hA0, 1'b0, "R4");
        do_load(15'h0800, 8'h5A, 1'b1, "R4");
        do_wait(1'b0, "R4");
        chk(!prot_on, "R4", prot_on, 0);
        do_done(1'b1, "R4");
        do_load(15'h5555, 8'hAA, 1'b0, "R10");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(prot_on, "R10", prot_on, 1);
        do_load(15'h2AAA, 8'h55, 1'b0, "R10");
        do_wait(1'b1, "R10");
        do_done(1'b1, "R10");

        // R1 power-up reset clears protection
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        chk(!prot_on && !id_mode, "R1", {prot_on, id_mode}, 0);

        // R3 partial sequence dropped by timeout
        do_load(15'h5555, 8'hAA, 1'b0, "R3");
        do_load(15'h2AAA, 8'h55, 1'b0, "R3");
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < WIN + 1; k++) begin
                @(negedge clk);
                if (prog_start) seen = 1'b1;
            end
            chk(!seen, "R3", seen, 0);
        end
        do_load(15'h5555, 8'hA0, 1'b1, "R3");
        do_wait(1'b0, "R3");
        do_done(1'b0, "R3");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule